// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a memory-mapped port of general-purpose pins. Software writes the levels the pins drive and chooses which pins drive at all. It reads back the synchronized level of every pad, whatever the pin's direction. Each pin can also be watched for a trigger condition: a low level, a high level, a rising edge or a falling edge. A detected condition sets a sticky event bit. Software clears that bit by writing a one to it.

Event bits are gated by a per-pin enable mask and then combined into two interrupt lines. One line covers the lower half of the pins and the other covers the upper half, so each half can be routed to its own interrupt controller input. The register bus is a plain synchronous one: a write takes effect at the clock edge where the write enable is high, and read data is registered at the edge where the read enable is high.

Pad inputs pass through a synchronizer before anything else looks at them. An edge is detected by comparing the synchronized level with its value one cycle earlier.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the output-value, direction, both trigger-configuration and mask registers read zero, pad_oe is all zero and both interrupt lines are low.
- R2: The output-value register (byte offset 0x00) drives pad_out. The direction register (offset 0x04) drives pad_oe, where a 1 makes the pin an output. Both read back what was written.
- R3: Offset 0x08 returns the level of pad_in after a two-flop synchronizer, for input and output pins alike. Writes to this offset change nothing.
- R4: Each pin has a 2-bit trigger code at bits [2k+1:2k], where k is the pin number modulo 16. Pins 0–15 take their codes from offset 0x0C and pins 16–31 from offset 0x10.
- R5: Trigger code 0 means low level, 1 high level, 2 rising edge and 3 falling edge.
- R6: A level-triggered event bit is set on every cycle its level holds, so clearing it while the level persists leaves it set.
- R7: An edge-triggered event bit is set once for each detected edge and stays cleared after a clear until the next such edge.
- R8: The event register at offset 0x18 is write-one-to-clear. A 1 in the write data clears that bit, a 0 leaves it alone, and without a write event bits never fall.
- R9: When a detection and a clearing write hit the same event bit in one cycle, the bit ends up set.
- R10: The mask register (offset 0x14) enables pins with a 1. irq_lo is high exactly when some pin in 0–15 has both event and mask set, and irq_hi likewise for pins 16–31.
- R11: Addresses with nonzero low two bits and word offsets above 0x18 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | BUS_W | Write data |
| rd_en | input | 1 | Read strobe; read data registered at this edge |
| rd_data | output | BUS_W | Registered read data |
| pad_in | input | PIN_W | Pad input levels (asynchronous) |
| pad_out | output | PIN_W | Pad output values |
| pad_oe | output | PIN_W | Pad output enables |
| irq_lo | output | 1 | Interrupt for pins 0 to PIN_W/2-1 |
| irq_hi | output | 1 | Interrupt for pins PIN_W/2 to PIN_W-1 |

## Verification
The trigger sweep gives every pin each of the four codes in turn, always with its neighbours on different codes, and pushes pad patterns through it before and after a clear. A field landing at the wrong bit position, or two codes swapped, shows up as a wrong event word. The bench times a rising edge so that its detection lands in the very cycle of a clearing write. If the clear took priority, the edge would be lost and the bit would read zero. Further checks cover a partial clear that must leave the other half set, a misaligned write that must not reach the output register, and a level pin that must refill at once after being cleared.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

   // Word indices of the registers (byte offset = index * 4)
   localparam int unsigned IDX_DOUT   = 0;
   localparam int unsigned IDX_DIR    = 1;
   localparam int unsigned IDX_PADS   = 2;
   localparam int unsigned IDX_CFG_LO = 3;
   localparam int unsigned IDX_CFG_HI = 4;
   localparam int unsigned IDX_MASK   = 5;
   localparam int unsigned IDX_EVT    = 6;
   localparam int unsigned NUM_REGS   = 7;

   typedef enum logic [1:0] {
      TRIG_LOW  = 2'd0,
      TRIG_HIGH = 2'd1,
      TRIG_RISE = 2'd2,
      TRIG_FALL = 2'd3
   } trig_e;

   function automatic logic trig_match(input trig_e code, input logic cur, input logic prev);
      logic m;
      case (code)
         TRIG_LOW:  m = ~cur;
         TRIG_HIGH: m = cur;
         TRIG_RISE: m = cur & ~prev;
         default:   m = ~cur & prev;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/gpio_pad_sync.sv
`timescale 1ns/1ps
module gpio_pad_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_prev
);

   logic [STAGES-1:0][W-1:0] chain;
   logic [W-1:0]             last;

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_pad_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         last  <= '0;
      end else begin
         chain <= {chain[STAGES-2:0], d};
         last  <= chain[STAGES-1];
      end
   end

   assign q      = chain[STAGES-1];
   assign q_prev = last;

endmodule

// File: rtl/gpio_trig_detect.sv
`timescale 1ns/1ps
module gpio_trig_detect
   import gpio_irq_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0]   cur,
   input  logic [W-1:0]   prev,
   input  logic [2*W-1:0] codes,
   output logic [W-1:0]   hit
);

   for (genvar i = 0; i < W; i++) begin : g_pin
      assign hit[i] = trig_match(trig_e'(codes[2*i +: 2]), cur[i], prev[i]);
   end

endmodule

// File: rtl/gpio_evt_status.sv
`timescale 1ns/1ps
module gpio_evt_status #(
   parameter int unsigned W    = 32,
   parameter int unsigned HALF = W / 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] hit,
   input  logic [W-1:0] clr,
   input  logic [W-1:0] mask,
   output logic [W-1:0] evt,
   output logic         irq_lo,
   output logic         irq_hi
);

   logic [W-1:0] pend;

   // a detection in the same cycle as a clear keeps the bit set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt <= '0;
      else        evt <= hit | (evt & ~clr);
   end

   assign pend   = evt & mask;
   assign irq_lo = |pend[HALF-1:0];
   assign irq_hi = |pend[W-1:HALF];

endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port
   import gpio_irq_pkg::*;
#(
   parameter int unsigned PIN_W       = 32,
   parameter int unsigned BUS_W       = 32,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [BUS_W-1:0]  wr_data,
   input  logic              rd_en,
   output logic [BUS_W-1:0]  rd_data,
   input  logic [PIN_W-1:0]  pad_in,
   output logic [PIN_W-1:0]  pad_out,
   output logic [PIN_W-1:0]  pad_oe,
   output logic              irq_lo,
   output logic              irq_hi
);

   localparam int unsigned HALF  = PIN_W / 2;
   localparam int unsigned CFG_W = 2 * HALF;
   localparam int unsigned IDX_W = ADDR_W - 2;

   // elaboration-time parameter checks
   if (PIN_W < 2 || (PIN_W % 2) != 0) begin : g_bad_pins
      $error("gpio_irq_port: PIN_W must be even and at least 2");
   end
   if (PIN_W > BUS_W) begin : g_bad_bus
      $error("gpio_irq_port: PIN_W must not exceed BUS_W");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("gpio_irq_port: ADDR_W too small for the register map");
   end

   // address decode
   logic                word_ok;
   logic [IDX_W-1:0]    idx;
   logic [NUM_REGS-1:0] sel;

   assign word_ok = (addr[1:0] == 2'b00);
   assign idx     = addr[ADDR_W-1:2];

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
      assign sel[r] = word_ok && (idx == IDX_W'(r));
   end

   // software registers
   logic [PIN_W-1:0] dout_q, dir_q, mask_q;
   logic [CFG_W-1:0] cfg_lo_q, cfg_hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q   <= '0;
         dir_q    <= '0;
         cfg_lo_q <= '0;
         cfg_hi_q <= '0;
         mask_q   <= '0;
      end else if (wr_en) begin
         if (sel[IDX_DOUT])   dout_q   <= wr_data[PIN_W-1:0];
         if (sel[IDX_DIR])    dir_q    <= wr_data[PIN_W-1:0];
         if (sel[IDX_CFG_LO]) cfg_lo_q <= wr_data[CFG_W-1:0];
         if (sel[IDX_CFG_HI]) cfg_hi_q <= wr_data[CFG_W-1:0];
         if (sel[IDX_MASK])   mask_q   <= wr_data[PIN_W-1:0];
      end
   end

   assign pad_out = dout_q;
   assign pad_oe  = dir_q;

   // input path
   logic [PIN_W-1:0] pad_s, pad_p, trig_hit, evt_q, evt_clr;

   gpio_pad_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      (pad_in),
      .q      (pad_s),
      .q_prev (pad_p)
   );

   gpio_trig_detect #(.W(PIN_W)) u_det (
      .cur   (pad_s),
      .prev  (pad_p),
      .codes ({cfg_hi_q, cfg_lo_q}),
      .hit   (trig_hit)
   );

   assign evt_clr = (wr_en && sel[IDX_EVT]) ? wr_data[PIN_W-1:0] : '0;

   gpio_evt_status #(.W(PIN_W), .HALF(HALF)) u_evt (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (trig_hit),
      .clr    (evt_clr),
      .mask   (mask_q),
      .evt    (evt_q),
      .irq_lo (irq_lo),
      .irq_hi (irq_hi)
   );

   // read path
   logic [BUS_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      if (sel[IDX_DOUT])   rd_mux[PIN_W-1:0] = dout_q;
      if (sel[IDX_DIR])    rd_mux[PIN_W-1:0] = dir_q;
      if (sel[IDX_PADS])   rd_mux[PIN_W-1:0] = pad_s;
      if (sel[IDX_CFG_LO]) rd_mux[CFG_W-1:0] = cfg_lo_q;
      if (sel[IDX_CFG_HI]) rd_mux[CFG_W-1:0] = cfg_hi_q;
      if (sel[IDX_MASK])   rd_mux[PIN_W-1:0] = mask_q;
      if (sel[IDX_EVT])    rd_mux[PIN_W-1:0] = evt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_mux;
   end

endmodule

// File: rtl/gpio_irq_port_chk.sv
`timescale 1ns/1ps
module gpio_irq_port_chk #(
   parameter int unsigned PIN_W  = 32,
   parameter int unsigned BUS_W  = 32,
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [BUS_W-1:0]  wr_data,
   input logic [PIN_W-1:0]  pad_out,
   input logic [PIN_W-1:0]  pad_oe,
   input logic [PIN_W-1:0]  trig_hit,
   input logic [PIN_W-1:0]  evt_q,
   input logic [PIN_W-1:0]  mask_q,
   input logic              irq_lo,
   input logic              irq_hi
);

   localparam int unsigned HALF = PIN_W / 2;
   localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(gpio_irq_pkg::IDX_DOUT * 4);
   localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(gpio_irq_pkg::IDX_DIR * 4);
   localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(gpio_irq_pkg::IDX_EVT * 4);

   AST_DOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_DOUT) |=> (pad_out == $past(wr_data[PIN_W-1:0]))); // R2
   AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_DIR) |=> (pad_oe == $past(wr_data[PIN_W-1:0]))); // R2
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|trig_hit) |=> ((evt_q & $past(trig_hit)) == $past(trig_hit))); // R9
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_EVT) |=> ((evt_q & $past(wr_data[PIN_W-1:0] & ~trig_hit)) == '0)); // R8
   AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == A_EVT) |=> ((evt_q & $past(evt_q)) == $past(evt_q))); // R8
   AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> (!irq_lo && !irq_hi)); // R10
   AST_IRQ_LO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_lo |-> (|evt_q[HALF-1:0])); // R10
   AST_IRQ_HI_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_hi |-> (|evt_q[PIN_W-1:HALF])); // R10

endmodule

bind gpio_irq_port gpio_irq_port_chk #(
   .PIN_W  (PIN_W),
   .BUS_W  (BUS_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr     (addr),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .pad_out  (pad_out),
   .pad_oe   (pad_oe),
   .trig_hit (trig_hit),
   .evt_q    (evt_q),
   .mask_q   (mask_q),
   .irq_lo   (irq_lo),
   .irq_hi   (irq_hi)
);

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;

   localparam logic [4:0] A_DOUT = 5'h00, A_DIR = 5'h04, A_PADS = 5'h08,
                          A_CLO = 5'h0C, A_CHI = 5'h10, A_MASK = 5'h14,
                          A_EVT = 5'h18, A_HOLE = 5'h1C, A_MIS = 5'h01;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  addr;
   logic        wr_en, rd_en;
   logic [31:0] wr_data, rd_data, pad_in, pad_out, pad_oe;
   logic        irq_lo, irq_hi;
   int          n_chk = 0, n_fail = 0, cyc = 0;

   always #2.5 clk = ~clk;

   gpio_irq_port u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired got=%0d exp<=100000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0; d = rd_data;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   // trigger code of pin p in sweep k: (p + k) mod 4
   function automatic logic [31:0] cfg_word(input int k, input int half);
      logic [31:0] w = '0;
      for (int j = 0; j < 16; j++) w[2*j +: 2] = 2'((half*16 + j + k) % 4);
      return w;
   endfunction

   function automatic logic [31:0] exp_evt(input int k, input logic [31:0] p,
                                           input logic [31:0] q, input bit after_q);
      logic [31:0] e = '0;
      for (int i = 0; i < 32; i++) begin
         case ((i + k) % 4)
            0: e[i] = after_q ? (~p[i] | ~q[i]) : ~p[i];
            1: e[i] = after_q ? (p[i] | q[i]) : p[i];
            2: e[i] = after_q ? (q[i] & ~p[i]) : 1'b0;
            default: e[i] = after_q ? (p[i] & ~q[i]) : 1'b0;
         endcase
      end
      return e;
   endfunction

   logic [31:0] v;
   logic [31:0] pats [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5C3_0F96, 32'h1234_5678};
   logic [31:0] pp [4]   = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h0F0F_3C3C};
   logic [31:0] qq [4]   = '{32'hFFFF_FFFF, 32'h0000_0000, 32'h5A5A_A5A5, 32'h00FF_FF00};
   logic [31:0] srcs [4] = '{32'h0000_0001, 32'h8000_0000, 32'h0000_8000, 32'h0001_0000};

   initial begin
      addr = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0; pad_in = '0;
      repeat (3) @(negedge clk);
      chk("R1 pad_oe in reset", pad_oe, 32'h0);
      chk("R1 pad_out in reset", pad_out, 32'h0);
      rst_n = 1'b1;
      rd(A_DOUT, v); chk("R1 dout", v, 0);
      rd(A_DIR, v);  chk("R1 dir", v, 0);
      rd(A_CLO, v);  chk("R1 cfg lo", v, 0);
      rd(A_CHI, v);  chk("R1 cfg hi", v, 0);
      rd(A_MASK, v); chk("R1 mask", v, 0);
      chk("R1 irq lines", {30'h0, irq_hi, irq_lo}, 32'h0);

      // R2 output value and direction
      for (int i = 0; i < 4; i++) begin
         wr(A_DOUT, pats[i]); wr(A_DIR, ~pats[i]);
         chk("R2 pad_out", pad_out, pats[i]);
         chk("R2 pad_oe", pad_oe, ~pats[i]);
         rd(A_DOUT, v); chk("R2 dout readback", v, pats[i]);
         rd(A_DIR, v);  chk("R2 dir readback", v, ~pats[i]);
      end

      // R3 pad level readback regardless of direction, write ignored
      for (int i = 0; i < 4; i++) begin
         wr(A_DIR, pats[(i + 1) % 4]);
         pad_in = pats[3 - i];
         settle();
         rd(A_PADS, v); chk("R3 pad level", v, pats[3 - i]);
      end
      wr(A_PADS, 32'hDEAD_BEEF);
      rd(A_PADS, v); chk("R3 write ignored", v, pats[0]);

      // R11 unmapped and misaligned addresses
      wr(A_DOUT, 32'h0BAD_F00D); wr(A_DIR, 32'h0000_FFFF);
      wr(A_HOLE, 32'hFFFF_FFFF); wr(A_MIS, 32'hFFFF_FFFF);
      rd(A_HOLE, v); chk("R11 hole reads zero", v, 0);
      rd(A_MIS, v);  chk("R11 misaligned reads zero", v, 0);
      rd(A_DOUT, v); chk("R11 dout untouched", v, 32'h0BAD_F00D);
      rd(A_DIR, v);  chk("R11 dir untouched", v, 32'h0000_FFFF);

      // R4 R5 R6 R7 trigger sweep, mask off
      for (int k = 0; k < 4; k++) begin
         wr(A_CLO, cfg_word(k, 0)); wr(A_CHI, cfg_word(k, 1));
         rd(A_CLO, v); chk("R4 cfg lo readback", v, cfg_word(k, 0));
         for (int t = 0; t < 4; t++) begin
            pad_in = pp[t]; settle();
            wr(A_EVT, 32'hFFFF_FFFF); settle();
            rd(A_EVT, v); chk("R4 R5 R6 R7 after clear", v, exp_evt(k, pp[t], qq[t], 1'b0));
            pad_in = qq[t]; settle();
            rd(A_EVT, v); chk("R4 R5 R6 R7 after change", v, exp_evt(k, pp[t], qq[t], 1'b1));
         end
      end

      // R9 edge detection in the same cycle as a clear; all pins rising
      wr(A_CLO, 32'hAAAA_AAAA); wr(A_CHI, 32'hAAAA_AAAA);
      pad_in = '0; settle();
      wr(A_EVT, 32'hFFFF_FFFF); settle();
      rd(A_EVT, v); chk("R7 cleared before edge", v, 0);
      @(negedge clk); pad_in = 32'hFFFF_FFFF;  // edge 1: stage 1, edge 2: hit
      @(negedge clk); @(negedge clk);
      addr = A_EVT; wr_data = 32'hFFFF_FFFF; wr_en = 1'b1; // lands with edge 3
      @(negedge clk); wr_en = 1'b0;
      rd(A_EVT, v); chk("R9 set beats clear", v, 32'hFFFF_FFFF);
      wr(A_EVT, 32'hFFFF_FFFF); settle();
      rd(A_EVT, v); chk("R7 no retrigger while held", v, 0);

      // R8 partial clear
      pad_in = '0; settle();
      wr(A_EVT, 32'hFFFF_FFFF);
      pad_in = 32'hFFFF_FFFF; settle();
      wr(A_EVT, 32'h0000_FFFF);
      rd(A_EVT, v); chk("R8 partial clear", v, 32'hFFFF_0000);
      wr(A_EVT, 32'h0000_0000);
      rd(A_EVT, v); chk("R8 zero write keeps", v, 32'hFFFF_0000);

      // R10 masking and halves
      for (int s = 0; s < 4; s++) begin
         wr(A_MASK, 32'h0);
         pad_in = '0; settle();
         wr(A_EVT, 32'hFFFF_FFFF); settle();
         pad_in = srcs[s]; settle();
         rd(A_EVT, v); chk("R10 event source", v, srcs[s]);
         for (int m = 0; m < 4; m++) begin
            logic [31:0] mk, hitm;
            mk = (m == 0) ? 32'h0 : (m == 1) ? 32'hFFFF_FFFF : (m == 2) ? srcs[s] : ~srcs[s];
            wr(A_MASK, mk);
            hitm = srcs[s] & mk;
            chk("R10 irq lines", {30'h0, irq_hi, irq_lo},
                {30'h0, |hitm[31:16], |hitm[15:0]});
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule